// File: doc/BRIEF.md
# Byte-Enabled Control Register Bank with FIFO Threshold Flag

This block is a slave register bank on a 64-bit control bus. A master raises a select line, chooses write or read with a single direction bit and names one of thirty-two 64-bit registers with a 5-bit word index, which stands for address bits 7:3. On a write, eight byte enables choose which 8-bit lanes of the addressed register take the new data. On a read, the whole register comes back in the same cycle.

One register holds a 6-bit threshold for a transmit FIFO. The bank compares the FIFO's current occupancy with that threshold and drives an almost-full flag from the result. A full indication from the FIFO forces the flag high regardless of the threshold. The FIFO storage and any meaning of the other registers lie outside this block.

Top module: `ctlRegBank`

## Requirements
- R1: When `cbSel` is 1 and `cbWrite` is 1 at a rising clock edge, the register at index `cbAddr` takes `cbWrData` in every byte lane n whose enable `cbByteEn[n]` is 1. Lane n covers bits 8n+7 down to 8n.
- R2: During a write, a lane whose byte enable is 0 keeps its previous value. Registers other than the addressed one are unchanged.
- R3: While `cbSel` is 0, no register changes, whatever the values of the direction bit, the address, the data and the byte enables.
- R4: When `cbSel` is 1 and `cbWrite` is 0, `cbRdData` shows the full 64-bit register at index `cbAddr` in the same cycle, and the byte enables have no effect. In every other cycle `cbRdData` is zero.
- R5: A synchronous active-high `rst` clears all 32 registers to zero.
- R6: The threshold is bits 61:56 of register index 13 (byte offset 0x68). `progFull` is 1 when `fifoLevel`, read as an unsigned number, is greater than or equal to that threshold.
- R7: With a threshold of zero, `progFull` is 1 at every occupancy, including zero. This includes the state right after reset.
- R8: `progFull` is 1 whenever `fifoFull` is 1.
- R9: Writes to other registers, to lanes 0 to 6 of register 13, and to bits 63:62 of register 13 leave the threshold, and so `progFull`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cbSel | input | 1 | Access select, active high |
| cbWrite | input | 1 | 1 = write, 0 = read |
| cbAddr | input | 5 | Register index (address bits 7:3) |
| cbByteEn | input | 8 | Write lane enables, bit n covers data bits 8n+7:8n |
| cbWrData | input | 64 | Write data |
| cbRdData | output | 64 | Read data, combinational |
| fifoLevel | input | 7 | Current FIFO occupancy |
| fifoFull | input | 1 | FIFO full indication |
| progFull | output | 1 | Programmable almost-full flag |

## Verification
A wrong register state shows on `cbRdData` as soon as that register is read. This is the cycle after the faulty write, because the read path has no pipeline stage. A corrupted threshold shows on `progFull` right after the clock edge that stored it. Sweeping every occupancy against every threshold therefore finds an off-by-one or a swapped bit within one cycle of the level change. Lane masking errors are separated out by readback after each of all 256 byte-enable patterns.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
  localparam int CB_DATA_W = 64;
  localparam int CB_LANES  = CB_DATA_W / 8;
  localparam int CB_ADDR_W = 5;
  localparam int CB_NREGS  = 1 << CB_ADDR_W;

  typedef struct packed {
    logic                 wrEn;
    logic [CB_NREGS-1:0]  wrSel;
    logic [CB_LANES-1:0]  laneMask;
    logic                 rdEn;
    logic [CB_ADDR_W-1:0] rdIdx;
  } bankStrobes_t;
endpackage

// File: rtl/ctlBankCtrl.sv
module ctlBankCtrl
  import ctlbank_pkg::*;
(
  input  logic                 selIn,
  input  logic                 writeIn,
  input  logic [CB_ADDR_W-1:0] addrIn,
  input  logic [CB_LANES-1:0]  byteEnIn,
  output bankStrobes_t         strobes
);
  logic doWrite;
  logic doRead;

  assign doWrite = selIn & writeIn;
  assign doRead  = selIn & ~writeIn;

  always_comb begin
    strobes          = '0;
    strobes.wrEn     = doWrite;
    strobes.rdEn     = doRead;
    strobes.rdIdx    = addrIn;
    strobes.laneMask = doWrite ? byteEnIn : '0;
    for (int r = 0; r < CB_NREGS; r++) begin
      strobes.wrSel[r] = doWrite && (addrIn == CB_ADDR_W'(r));
    end
  end
endmodule

// File: rtl/ctlBankData.sv
module ctlBankData
  import ctlbank_pkg::*;
#(
  parameter int THRESH_IDX = 13,
  parameter int THRESH_LSB = 56,
  parameter int THRESH_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bankStrobes_t         strobes,
  input  logic [CB_DATA_W-1:0] wrData,
  output logic [CB_DATA_W-1:0] rdData,
  output logic [THRESH_W-1:0]  threshVal
);
  logic [CB_DATA_W-1:0] regFile [CB_NREGS];

  for (genvar r = 0; r < CB_NREGS; r++) begin : g_reg
    for (genvar l = 0; l < CB_LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          regFile[r][8*l +: 8] <= '0;
        end else if (strobes.wrEn && strobes.wrSel[r] && strobes.laneMask[l]) begin
          regFile[r][8*l +: 8] <= wrData[8*l +: 8];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdEn) rdData = regFile[strobes.rdIdx];
  end

  assign threshVal = regFile[THRESH_IDX][THRESH_LSB +: THRESH_W];
endmodule

// File: rtl/ctlBankThresh.sv
module ctlBankThresh #(
  parameter int THRESH_W = 6,
  parameter int LEVEL_W  = 7
) (
  input  logic [THRESH_W-1:0] threshVal,
  input  logic [LEVEL_W-1:0]  level,
  input  logic                full,
  output logic                flag
);
  localparam int CMP_W = (LEVEL_W > THRESH_W) ? LEVEL_W : THRESH_W;

  logic [CMP_W-1:0] levelExt;
  logic [CMP_W-1:0] threshExt;

  assign levelExt  = CMP_W'(level);
  assign threshExt = CMP_W'(threshVal);
  assign flag      = full | (levelExt >= threshExt);
endmodule

// File: rtl/ctlRegBank.sv
module ctlRegBank
  import ctlbank_pkg::*;
#(
  parameter int THRESH_IDX = 13,
  parameter int THRESH_LSB = 56,
  parameter int THRESH_W   = 6,
  parameter int LEVEL_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cbSel,
  input  logic                 cbWrite,
  input  logic [CB_ADDR_W-1:0] cbAddr,
  input  logic [CB_LANES-1:0]  cbByteEn,
  input  logic [CB_DATA_W-1:0] cbWrData,
  output logic [CB_DATA_W-1:0] cbRdData,
  input  logic [LEVEL_W-1:0]   fifoLevel,
  input  logic                 fifoFull,
  output logic                 progFull
);
  bankStrobes_t        strobes;
  logic [THRESH_W-1:0] threshVal;

  ctlBankCtrl i_ctrl (
    .selIn    (cbSel),
    .writeIn  (cbWrite),
    .addrIn   (cbAddr),
    .byteEnIn (cbByteEn),
    .strobes  (strobes)
  );

  ctlBankData #(
    .THRESH_IDX (THRESH_IDX),
    .THRESH_LSB (THRESH_LSB),
    .THRESH_W   (THRESH_W)
  ) i_data (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .wrData    (cbWrData),
    .rdData    (cbRdData),
    .threshVal (threshVal)
  );

  ctlBankThresh #(
    .THRESH_W (THRESH_W),
    .LEVEL_W  (LEVEL_W)
  ) i_thresh (
    .threshVal (threshVal),
    .level     (fifoLevel),
    .full      (fifoFull),
    .flag      (progFull)
  );
endmodule

// File: rtl/ctlRegBank_chk.sv
module ctlRegBank_chk
  import ctlbank_pkg::*;
#(
  parameter int THRESH_IDX = 13,
  parameter int THRESH_LSB = 56,
  parameter int THRESH_W   = 6,
  parameter int LEVEL_W    = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cbSel,
  input logic                 cbWrite,
  input logic [CB_ADDR_W-1:0] cbAddr,
  input logic [CB_LANES-1:0]  cbByteEn,
  input logic [CB_DATA_W-1:0] cbWrData,
  input logic [CB_DATA_W-1:0] cbRdData,
  input logic [LEVEL_W-1:0]   fifoLevel,
  input logic                 fifoFull,
  input logic                 progFull
);
  localparam int LANE_T = THRESH_LSB / 8;

  logic [THRESH_W-1:0] shadowThr;
  logic                seenClk;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowThr <= '0;
      seenClk   <= 1'b1;
    end else if (cbSel && cbWrite && cbAddr == CB_ADDR_W'(THRESH_IDX) && cbByteEn[LANE_T]) begin
      shadowThr <= cbWrData[THRESH_LSB +: THRESH_W];
    end
  end

  // R4
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst || !seenClk)
    !(cbSel && !cbWrite) |-> cbRdData == '0);

  // R8
  full_forces_flag_chk: assert property (@(posedge clk) disable iff (rst || !seenClk)
    fifoFull |-> progFull);

  // R6
  flag_matches_thr_chk: assert property (@(posedge clk) disable iff (rst || !seenClk)
    progFull == (fifoFull || (32'(fifoLevel) >= 32'(shadowThr))));

  // R1
  full_write_readback_chk: assert property (@(posedge clk) disable iff (rst || !seenClk)
    (cbSel && cbWrite && cbByteEn == '1) |=>
      (!(cbSel && !cbWrite && cbAddr == $past(cbAddr)) || cbRdData == $past(cbWrData)));

  // R7
  zero_thr_flag_chk: assert property (@(posedge clk) disable iff (rst || !seenClk)
    (shadowThr == '0) |-> progFull);
endmodule

bind ctlRegBank ctlRegBank_chk #(
  .THRESH_IDX (THRESH_IDX),
  .THRESH_LSB (THRESH_LSB),
  .THRESH_W   (THRESH_W),
  .LEVEL_W    (LEVEL_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cbSel     (cbSel),
  .cbWrite   (cbWrite),
  .cbAddr    (cbAddr),
  .cbByteEn  (cbByteEn),
  .cbWrData  (cbWrData),
  .cbRdData  (cbRdData),
  .fifoLevel (fifoLevel),
  .fifoFull  (fifoFull),
  .progFull  (progFull)
);

// File: tb/test_ctlRegBank.sv
module test_ctlRegBank;
  logic        clk = 1'b0;
  logic        rst;
  logic        cbSel;
  logic        cbWrite;
  logic [4:0]  cbAddr;
  logic [7:0]  cbByteEn;
  logic [63:0] cbWrData;
  logic [63:0] cbRdData;
  logic [6:0]  fifoLevel;
  logic        fifoFull;
  logic        progFull;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [63:0] mdl [32];

  always #10 clk = ~clk;

  ctlRegBank i_ctlRegBank (
    .clk(clk), .rst(rst), .cbSel(cbSel), .cbWrite(cbWrite), .cbAddr(cbAddr),
    .cbByteEn(cbByteEn), .cbWrData(cbWrData), .cbRdData(cbRdData),
    .fifoLevel(fifoLevel), .fifoFull(fifoFull), .progFull(progFull)
  );

  function automatic logic [63:0] laneMask(input logic [7:0] be);
    logic [63:0] m = '0;
    for (int l = 0; l < 8; l++) if (be[l]) m[8*l +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [63:0] pat(input int a, input int k);
    return {32'(a * 32'h9E37 + k), 32'(k * 32'h85EB + a * 7 + 1)};
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    cbSel = 1; cbWrite = 1; cbAddr = 5'(a); cbWrData = d; cbByteEn = be;
    @(negedge clk);
    cbSel = 0; cbWrite = 0;
    mdl[a] = (mdl[a] & ~laneMask(be)) | (d & laneMask(be));
  endtask

  task automatic doRead(input int a, input logic [7:0] be, output logic [63:0] q);
    @(negedge clk);
    cbSel = 1; cbWrite = 0; cbAddr = 5'(a); cbByteEn = be;
    #1 q = cbRdData;
    #1 cbSel = 0;
  endtask

  task automatic checkAll(input string req);
    logic [63:0] q;
    for (int a = 0; a < 32; a++) begin
      doRead(a, 8'hFF, q);
      check64(req, q, mdl[a]);
    end
  endtask

  function automatic logic expFlag(input int lvl, input logic full);
    return full || (lvl >= int'(mdl[13][61:56]));
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] q;
    rst = 1; cbSel = 0; cbWrite = 0; cbAddr = 0; cbByteEn = 0; cbWrData = 0;
    fifoLevel = 0; fifoFull = 0;
    for (int a = 0; a < 32; a++) mdl[a] = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R5: every register reads zero after reset
    checkAll("R5");
    // R7: zero threshold after reset flags at occupancy 0
    #1 check1("R7", progFull, 1'b1);

    // R4: output is zero when no read is selected
    @(negedge clk); #1 check64("R4", cbRdData, 64'h0);

    // R1: full writes to every register
    for (int a = 0; a < 32; a++) doWrite(a, pat(a, 1), 8'hFF);
    checkAll("R1");

    // R2: all 256 byte-enable patterns on two registers
    for (int be = 0; be < 256; be++) begin
      doWrite(5, pat(5, be + 7), 8'(be));
      doRead(5, 8'hFF, q);
      check64("R2", q, mdl[5]);
      doWrite(22, ~pat(22, be), 8'(be));
      doRead(22, 8'hFF, q);
      check64("R2", q, mdl[22]);
    end
    checkAll("R2");

    // R3: deselected write cycles change nothing
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      cbSel = 0; cbWrite = 1; cbAddr = 5'(a); cbByteEn = 8'hFF; cbWrData = ~mdl[a];
      @(negedge clk);
      #1 check64("R4", cbRdData, 64'h0);
      cbWrite = 0;
    end
    checkAll("R3");

    // R4: byte enables ignored on reads
    for (int be = 0; be < 256; be += 17) begin
      doRead(9, 8'(be), q);
      check64("R4", q, mdl[9]);
    end

    // R6: sweep every threshold against occupancies 0..80
    for (int t = 0; t < 64; t++) begin
      doWrite(13, {2'b11, 6'(t), 56'h0}, 8'h80);
      for (int lvl = 0; lvl <= 80; lvl++) begin
        @(negedge clk);
        fifoLevel = 7'(lvl); fifoFull = 0;
        #1 check1("R6", progFull, expFlag(lvl, 1'b0));
      end
    end

    // R8: full forces the flag
    doWrite(13, {2'b00, 6'd63, 56'h0}, 8'h80);
    for (int lvl = 0; lvl < 64; lvl += 5) begin
      @(negedge clk);
      fifoLevel = 7'(lvl); fifoFull = 1;
      #1 check1("R8", progFull, 1'b1);
    end
    @(negedge clk);
    fifoFull = 0; fifoLevel = 7'd10;
    #1 check1("R8", progFull, 1'b0);

    // R9: threshold untouched by other registers and lanes
    doWrite(13, 64'hC0FF_FFFF_FFFF_FFFF, 8'h7F);
    doWrite(12, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    doWrite(14, 64'h0, 8'hFF);
    doWrite(13, 64'hFF00_0000_0000_0000 & {2'b00, 6'd40, 56'h0} | 64'hC000_0000_0000_0000, 8'h80);
    for (int lvl = 38; lvl <= 42; lvl++) begin
      @(negedge clk);
      fifoLevel = 7'(lvl);
      #1 check1("R9", progFull, expFlag(lvl, 1'b0));
    end
    doRead(13, 8'h00, q);
    check64("R9", q, mdl[13]);

    // R7: zero threshold again, occupancy zero
    doWrite(13, 64'h0, 8'h80);
    @(negedge clk);
    fifoLevel = 0;
    #1 check1("R7", progFull, 1'b1);

    // R5: reset mid-run clears everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int a = 0; a < 32; a++) mdl[a] = '0;
    checkAll("R5");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule